// File: doc/BRIEF.md
# Receive Data-Block Audio/MIDI Deinterleaver

This block sits behind the isochronous receive path for one stream. It takes the stream's 32-bit quadlets one per cycle, groups them into data blocks, and routes each quadlet by its position in the block. A set number of leading quadlets is dropped. The next quadlets are audio samples, one per channel, with channel 0 first. A single MIDI quadlet follows them when one or more MIDI ports are configured. Each audio sample goes out with its channel index and a label flag, which is taken from a per-channel enable mask.

Software starts the stream with a write strobe that carries a nonzero value and stops it with a write strobe that carries zero. A start is accepted only if the stream's channel number is valid. The value of all ones marks the stream as unused. At each accepted start the block freezes the skip count, the audio channel count and the MIDI presence. The label mask stays live throughout. Every block is `skip + audio + (midi ? 1 : 0)` quadlets long. A block-start marker that arrives before the current block is complete raises a length error, and parsing restarts from that quadlet.

Top module: `rx_block_deint`

## Requirements
- R1: After reset the stream is stopped, and `smp_valid_o`, `midi_valid_o` and `len_err_o` are 0.
- R2: A write with `en_val_i`=1 while `cfg_chan_i` is not all ones (6'h3F) starts the stream. A write with `en_val_i`=0 stops it. A write with `en_val_i`=1 while `cfg_chan_i` is all ones leaves the stream stopped. A stopped stream produces no strobe for any input quadlet.
- R3: After each start, the block discards quadlets until the first quadlet that carries `q_sob_i`=1. That quadlet is position 0 of a block.
- R4: In every block, positions 0 to skip-1 produce no output strobe.
- R5: Positions skip to skip+N-1, where N is the audio count, each raise `smp_valid_o` for one cycle, on the cycle after the quadlet is accepted. On that cycle `smp_ch_o` equals the position minus skip, and `smp_data_o` equals the quadlet unchanged, with the first byte on the wire in bits 31:24.
- R6: When the MIDI port count (0 to 8) is nonzero, position skip+N raises `midi_valid_o` for one cycle, with `midi_data_o` equal to that quadlet. When the count is zero, the block has no MIDI position. `smp_valid_o` and `midi_valid_o` are never high together.
- R7: After the last position of a block, the next quadlet is position 0 of a new block, even if it carries no marker.
- R8: `smp_label_o` equals the bit of `label_mask_i` for that sample's channel, as the mask stood in the cycle the quadlet was accepted. A change to the mask applies from the next sample on.
- R9: A change to the skip count, the audio count or the MIDI count while the stream runs has no effect until the next start.
- R10: A marker quadlet that arrives while a synchronised block is incomplete raises `len_err_o` for one cycle and becomes position 0 of a new block. A marker that arrives at a block boundary raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Strobe for a write to the stream enable |
| en_val_i | input | 1 | Value written: 1 starts or restarts the stream, 0 stops it |
| cfg_chan_i | input | CHN_W | Isochronous channel number; all ones means the stream is unused |
| cfg_skip_i | input | SKIP_W | Number of leading quadlets dropped in each block |
| cfg_naudio_i | input | CNT_W | Number of audio channels, 0 to MAX_CH |
| cfg_nmidi_i | input | 4 | Number of MIDI ports, 0 to 8 |
| label_mask_i | input | MAX_CH | Label enable, one bit per channel |
| q_valid_i | input | 1 | Input quadlet valid |
| q_sob_i | input | 1 | Marks the quadlet that starts a block |
| q_data_i | input | 32 | Input quadlet, big-endian |
| smp_valid_o | output | 1 | Audio sample strobe |
| smp_ch_o | output | IDX_W | Channel index of the sample |
| smp_data_o | output | 32 | Sample quadlet |
| smp_label_o | output | 1 | Label flag of the sample |
| midi_valid_o | output | 1 | MIDI quadlet strobe |
| midi_data_o | output | 32 | MIDI quadlet |
| len_err_o | output | 1 | One-cycle pulse for a marker that arrives inside a block |

## Verification
The bench builds the block with MAX_CH=4 and SKIP_MAX=3. At that size it can sweep every skip count from 0 to 3 and every audio count from 1 to 4, each with MIDI ports set to 0, 1 and 8. Each configuration runs two back-to-back blocks, so every slot kind is visited, and so is the wrap into an unmarked second block. The label mask changes on every quadlet. Directed sequences cover the cases the sweep does not reach: running before sync, a config change while running, a marker that arrives early or on a boundary, a stop, and an unused channel number.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    SLOT_DROP  = 2'd0,
    SLOT_AUDIO = 2'd1,
    SLOT_MIDI  = 2'd2
  } slot_e;
endpackage

// File: rtl/rxd_ctrl.sv
module rxd_ctrl #(
  parameter int CHN_W  = 6,
  parameter int SKIP_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic [CHN_W-1:0]  cfg_chan_i,
  input  logic [SKIP_W-1:0] cfg_skip_i,
  input  logic [CNT_W-1:0]  cfg_naudio_i,
  input  logic [3:0]        cfg_nmidi_i,
  output logic              run_o,
  output logic              start_o,
  output logic [SKIP_W-1:0] skip_o,
  output logic [CNT_W-1:0]  na_o,
  output logic              has_midi_o
);
  logic chan_ok;
  assign chan_ok = (cfg_chan_i != '1);
  assign start_o = en_wr_i && en_val_i && chan_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o      <= 1'b0;
      skip_o     <= '0;
      na_o       <= '0;
      has_midi_o <= 1'b0;
    end else if (en_wr_i) begin
      run_o <= start_o;
      if (start_o) begin
        skip_o     <= cfg_skip_i;
        na_o       <= cfg_naudio_i;
        has_midi_o <= (cfg_nmidi_i != 4'd0);
      end
    end
  end

  // R9: frozen config only moves on an accepted start
  assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> $stable(na_o) && $stable(skip_o) && $stable(has_midi_o));
endmodule

// File: rtl/rxd_pos.sv
module rxd_pos #(
  parameter int POS_W  = 5,
  parameter int SKIP_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              q_valid_i,
  input  logic              q_sob_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  na_i,
  input  logic              has_midi_i,
  output logic              take_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              len_err_o
);
  logic [POS_W-1:0] pos_q, blk_len, nxt;
  logic             synced_q;

  assign blk_len = POS_W'(skip_i) + POS_W'(na_i) + POS_W'(has_midi_i);
  assign pos_o   = q_sob_i ? '0 : pos_q;
  assign nxt     = pos_o + POS_W'(1);
  assign take_o  = q_valid_i && run_i && (synced_q || q_sob_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      synced_q  <= 1'b0;
      len_err_o <= 1'b0;
    end else if (start_i) begin
      pos_q     <= '0;
      synced_q  <= 1'b0;
      len_err_o <= 1'b0;
    end else begin
      len_err_o <= take_o && q_sob_i && synced_q && (pos_q != '0);
      if (take_o) begin
        pos_q    <= (nxt >= blk_len) ? '0 : nxt;
        synced_q <= 1'b1;
      end
    end
  end

  assert_pos_in_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (blk_len != '0) |-> pos_q < blk_len);
  assert_err_needs_marker_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> $past(q_valid_i && q_sob_i && run_i));
endmodule

// File: rtl/rxd_route.sv
module rxd_route
  import rxd_pkg::*;
#(
  parameter int POS_W  = 5,
  parameter int SKIP_W = 4,
  parameter int CNT_W  = 5,
  parameter int MAX_CH = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  na_i,
  input  logic              has_midi_i,
  input  logic [31:0]       q_data_i,
  input  logic [MAX_CH-1:0] label_mask_i,
  output logic              smp_valid_o,
  output logic [IDX_W-1:0]  smp_ch_o,
  output logic              smp_label_o,
  output logic              midi_valid_o,
  output logic [31:0]       data_o
);
  slot_e            slot;
  logic [POS_W-1:0] aud_end;
  logic [IDX_W-1:0] ch_c;

  assign aud_end = POS_W'(skip_i) + POS_W'(na_i);
  assign ch_c    = IDX_W'(pos_i - POS_W'(skip_i));

  always_comb begin
    slot = SLOT_DROP;
    if (pos_i >= POS_W'(skip_i) && pos_i < aud_end) slot = SLOT_AUDIO;
    else if (has_midi_i && pos_i == aud_end)         slot = SLOT_MIDI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_valid_o  <= 1'b0;
      midi_valid_o <= 1'b0;
      smp_ch_o     <= '0;
      smp_label_o  <= 1'b0;
      data_o       <= '0;
    end else begin
      smp_valid_o  <= take_i && (slot == SLOT_AUDIO);
      midi_valid_o <= take_i && (slot == SLOT_MIDI);
      if (take_i) begin
        data_o <= q_data_i;
        if (slot == SLOT_AUDIO) begin
          smp_ch_o    <= ch_c;
          smp_label_o <= label_mask_i[ch_c];
        end
      end
    end
  end

  assert_one_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_valid_o && midi_valid_o));
  assert_ch_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> CNT_W'(smp_ch_o) < $past(na_i));
  assert_strobe_needs_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o || midi_valid_o) |-> $past(take_i));
endmodule

// File: rtl/rx_block_deint.sv
module rx_block_deint #(
  parameter int MAX_CH   = 16,
  parameter int SKIP_MAX = 15,
  parameter int CHN_W    = 6,
  localparam int CNT_W   = $clog2(MAX_CH + 1),
  localparam int IDX_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
  localparam int SKIP_W  = (SKIP_MAX > 0) ? $clog2(SKIP_MAX + 1) : 1,
  localparam int POS_W   = $clog2(SKIP_MAX + MAX_CH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic [CHN_W-1:0]  cfg_chan_i,
  input  logic [SKIP_W-1:0] cfg_skip_i,
  input  logic [CNT_W-1:0]  cfg_naudio_i,
  input  logic [3:0]        cfg_nmidi_i,
  input  logic [MAX_CH-1:0] label_mask_i,
  input  logic              q_valid_i,
  input  logic              q_sob_i,
  input  logic [31:0]       q_data_i,
  output logic              smp_valid_o,
  output logic [IDX_W-1:0]  smp_ch_o,
  output logic [31:0]       smp_data_o,
  output logic              smp_label_o,
  output logic              midi_valid_o,
  output logic [31:0]       midi_data_o,
  output logic              len_err_o
);
  logic              run, start, has_midi, take;
  logic [SKIP_W-1:0] skip;
  logic [CNT_W-1:0]  na;
  logic [POS_W-1:0]  pos;
  logic [31:0]       data;

  rxd_ctrl #(.CHN_W(CHN_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .en_wr_i, .en_val_i, .cfg_chan_i, .cfg_skip_i,
    .cfg_naudio_i, .cfg_nmidi_i,
    .run_o(run), .start_o(start), .skip_o(skip), .na_o(na), .has_midi_o(has_midi)
  );

  rxd_pos #(.POS_W(POS_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W)) u_pos (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .q_valid_i, .q_sob_i,
    .skip_i(skip), .na_i(na), .has_midi_i(has_midi),
    .take_o(take), .pos_o(pos), .len_err_o
  );

  rxd_route #(.POS_W(POS_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W),
              .MAX_CH(MAX_CH), .IDX_W(IDX_W)) u_route (
    .clk_i, .rst_ni, .take_i(take), .pos_i(pos), .skip_i(skip), .na_i(na),
    .has_midi_i(has_midi), .q_data_i, .label_mask_i,
    .smp_valid_o, .smp_ch_o, .smp_label_o, .midi_valid_o, .data_o(data)
  );

  assign smp_data_o  = data;
  assign midi_data_o = data;

  assert_stopped_is_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !smp_valid_o && !midi_valid_o && !len_err_o);
endmodule

// File: tb/rx_block_deint_bench.sv
`timescale 1ns/1ps
module rx_block_deint_bench;
  localparam int MAX_CH = 4, SKIP_MAX = 3, CHN_W = 6;
  localparam int CNT_W = 3, IDX_W = 2, SKIP_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_wr = 0, en_val = 0, q_valid = 0, q_sob = 0;
  logic [CHN_W-1:0]  cfg_chan = 6'd5;
  logic [SKIP_W-1:0] cfg_skip = '0;
  logic [CNT_W-1:0]  cfg_na = '0;
  logic [3:0]        cfg_nm = '0;
  logic [MAX_CH-1:0] mask = '0;
  logic [31:0]       q_data = '0;
  logic              sv, lbl, mv, err;
  logic [IDX_W-1:0]  ch;
  logic [31:0]       sd, md;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_block_deint #(.MAX_CH(MAX_CH), .SKIP_MAX(SKIP_MAX), .CHN_W(CHN_W)) u_rx_block_deint (
    .clk_i(clk), .rst_ni(rst_n), .en_wr_i(en_wr), .en_val_i(en_val),
    .cfg_chan_i(cfg_chan), .cfg_skip_i(cfg_skip), .cfg_naudio_i(cfg_na),
    .cfg_nmidi_i(cfg_nm), .label_mask_i(mask), .q_valid_i(q_valid),
    .q_sob_i(q_sob), .q_data_i(q_data), .smp_valid_o(sv), .smp_ch_o(ch),
    .smp_data_o(sd), .smp_label_o(lbl), .midi_valid_o(mv), .midi_data_o(md),
    .len_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic v);
    @(negedge clk); en_wr = 1'b1; en_val = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic sob);
    @(negedge clk); q_valid = 1'b1; q_data = d; q_sob = sob;
    @(posedge clk); #1;
    q_valid = 1'b0; q_sob = 1'b0;
  endtask

  task automatic silent(input string req);
    chk(req, {30'd0, sv, mv}, 32'd0);
  endtask

  // expected outcome of a quadlet at block position p under config (s,n,m)
  task automatic push_chk(input logic [31:0] d, input logic sob, input int p,
                          input int s, input int n, input int m);
    logic [MAX_CH-1:0] mk;
    mk = mask;
    push(d, sob);
    if (p < s) silent("R4 skip slot");
    else if (p < s + n) begin
      chk("R5 sample valid", {30'd0, sv, mv}, 32'd2);
      chk("R5 channel", 32'(ch), 32'(p - s));
      chk("R5 data", sd, d);
      chk("R8 label", 32'(lbl), 32'(mk[p - s]));
    end else if (m > 0 && p == s + n) begin
      chk("R6 midi valid", {30'd0, sv, mv}, 32'd1);
      chk("R6 midi data", md, d);
    end else silent("R6 no extra slot");
    chk("R10 no length error", 32'(err), 32'd0);
  endtask

  task automatic set_cfg(input int s, input int n, input int m);
    cfg_skip = SKIP_W'(s); cfg_na = CNT_W'(n); cfg_nm = 4'(m);
  endtask

  task automatic run_block(input int s, input int n, input int m, input int b, input bit sob);
    int blk;
    blk = s + n + ((m > 0) ? 1 : 0);
    for (int p = 0; p < blk; p++) begin
      mask = MAX_CH'(p * 3 + b + s + 5);
      push_chk(32'hA500_0000 | 32'(s << 16) | 32'(n << 12) | 32'(m << 8) | 32'(b << 4) | 32'(p),
               sob && p == 0, p, s, n, m);
    end
  endtask

  initial begin
    int mvals[3];
    mvals[0] = 0; mvals[1] = 1; mvals[2] = 8;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset strobes", {29'd0, sv, mv, err}, 32'd0);
    rst_n = 1'b1;
    set_cfg(1, 2, 1);
    push(32'h1111_0000, 1'b1);
    silent("R2 never started");

    // R3: quadlets before the first marker are dropped
    wr_en(1'b1);
    for (int i = 0; i < 3; i++) begin
      push(32'h2222_0000 + 32'(i), 1'b0);
      silent("R3 pre-sync drop");
    end
    run_block(1, 2, 1, 0, 1'b1);

    // full sweep with marked block then unmarked block (R7)
    for (int s = 0; s <= SKIP_MAX; s++)
      for (int n = 1; n <= MAX_CH; n++)
        for (int mi = 0; mi < 3; mi++) begin
          set_cfg(s, n, mvals[mi]);
          wr_en(1'b1);
          run_block(s, n, mvals[mi], 0, 1'b1);
          run_block(s, n, mvals[mi], 1, 1'b0);
        end

    // R9: config change while running does nothing until restart
    set_cfg(1, 2, 0);
    wr_en(1'b1);
    set_cfg(0, 4, 8);
    run_block(1, 2, 0, 0, 1'b1);
    run_block(1, 2, 0, 1, 1'b0);
    wr_en(1'b1);
    run_block(0, 4, 8, 0, 1'b1);

    // R10: early marker
    set_cfg(1, 3, 1);
    wr_en(1'b1);
    run_block(1, 3, 1, 0, 1'b1);
    mask = 4'b0001;
    push_chk(32'hE000_0000, 1'b1, 0, 1, 3, 1);
    push_chk(32'hE000_0001, 1'b0, 1, 1, 3, 1);
    push(32'hE000_0002, 1'b1);
    chk("R10 early marker error", 32'(err), 32'd1);
    silent("R10 restart at position 0");
    mask = 4'b0010;
    push(32'hE000_0003, 1'b0);
    chk("R10 error is one pulse", 32'(err), 32'd0);
    chk("R10 resumed channel", {29'd0, sv, ch, lbl}, {29'd0, 1'b1, 2'd0, 1'b0});
    push_chk(32'hE000_0004, 1'b0, 2, 1, 3, 1);
    push_chk(32'hE000_0005, 1'b0, 3, 1, 3, 1);
    push_chk(32'hE000_0006, 1'b0, 4, 1, 3, 1);
    run_block(1, 3, 1, 2, 1'b1);

    // R2: stop, and unused channel
    wr_en(1'b0);
    push(32'h3333_0000, 1'b1);
    silent("R2 stopped");
    push(32'h3333_0001, 1'b0);
    silent("R2 stopped");
    cfg_chan = 6'h3F;
    wr_en(1'b1);
    for (int i = 0; i < 4; i++) begin
      push(32'h4444_0000 + 32'(i), i == 0);
      chk("R2 unused channel silent", {29'd0, sv, mv, err}, 32'd0);
    end
    cfg_chan = 6'd0;
    wr_en(1'b1);
    run_block(1, 3, 1, 0, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule